// File: doc/BRIEF.md
# Programmable Flag Offset Register Bank

This block stores the two thresholds a FIFO uses for its almost-empty and almost-full flags. Each threshold is held as a group of byte-wide sub-registers, two or three per threshold depending on a parameter. The thresholds can be loaded one byte per clock over the FIFO write-data bus, or one bit per clock from a serial input. Either way they can be read back one byte per clock over the read-data bus. The fill-level comparison that turns the thresholds into flags sits outside this block.

The loading method is fixed at master reset by the level of the load-select pin. That level also picks the default threshold: 127 for byte loading and 1023 for bit loading. Byte writes and byte readback each step their own cycling pointer. Bit loading steps its own bit counter. All three are cleared only by master reset, so any loading or readback sequence can be paused for FIFO traffic and then resumed where it stopped.

Each threshold has a valid output, which the flag logic downstream uses to suppress a flag while its threshold is only partly written. While load select is high, the write and read enables pass through to the FIFO path, and the read-data register captures FIFO data.

Top module: `flag_offset_bank`

## Requirements
- R1: Each threshold is `BYTES_PER_OFS` sub-registers of `SUB_W` bits. Sub-register k (0 = least significant) holds bits k*SUB_W upward. Threshold bytes are ordered empty LSB to empty MSB, then full LSB to full MSB, as indices 0 to 2*BYTES_PER_OFS-1. Both thresholds are always visible on `empty_ofs_o` and `full_ofs_o`.
- R2: In byte-load mode, each clock edge with `ld_ni`=0 and `wen_ni`=0 writes `wdata_i[SUB_W-1:0]` into the sub-register at the write pointer. The pointer then advances in index order and wraps from the last full byte to empty LSB.
- R3: In either mode, each clock edge with `ld_ni`=0 and `ren_ni`=0 loads the sub-register at the readback pointer, zero-extended, into `rdata_o`. The readback pointer then advances with the same order and wrap as the write pointer and independently of it.
- R4: In bit-load mode, each clock edge with `ld_ni`=0 and `sen_ni`=0 stores `si_i` into bit n of the concatenation {full, empty}, where n counts 0 to 2*BYTES_PER_OFS*SUB_W-1 and then wraps to 0. With the defaults this is 32 bits, the first going to the empty LSB.
- R5: Bit loading stores nothing on an edge where `sen_ni` or `ld_ni` is high. It continues with the next bit position once both are low again.
- R6: In bit-load mode both valid outputs go low on the edge that stores bit 0. Both go high on the edge that stores the last bit. The two valid outputs are always equal in this mode.
- R7: In byte-load mode, writing a threshold's LSB byte drops that threshold's valid output, and writing its MSB byte raises it. The other threshold's valid output is unaffected.
- R8: Master reset (`rst_ni`=0) selects byte-load mode with both thresholds at `DFLT_PAR` (127) if `ld_ni`=0, or bit-load mode with both at `DFLT_SER` (1023) if `ld_ni`=1. It also sets both valid outputs to 1, zeroes all pointers and zeroes `rdata_o`. The mode then stays fixed until the next master reset.
- R9: In byte-load mode, `sen_ni` and `si_i` have no effect. In bit-load mode, `ld_ni`=0 with `wen_ni`=0 writes nothing.
- R10: An edge with `prst_ni`=0 clears `rdata_o` to 0. It leaves the thresholds, the valid outputs, the pointers, the bit position and the mode unchanged.
- R11: `fifo_wr_o` = `ld_ni` & ~`wen_ni` and `fifo_rd_o` = `ld_ni` & ~`ren_ni`. With `ld_ni`=1 the thresholds do not change. An edge with `ld_ni`=1 and `ren_ni`=0 loads `fifo_rdata_i` into `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| prst_ni | input | 1 | Partial reset, synchronous, active low |
| ld_ni | input | 1 | Load select, active low; also picks the mode during master reset |
| sen_ni | input | 1 | Serial enable, active low |
| si_i | input | 1 | Serial data bit |
| wen_ni | input | 1 | Write enable, active low |
| wdata_i | input | DATA_W | Write data bus |
| ren_ni | input | 1 | Read enable, active low |
| fifo_rdata_i | input | DATA_W | Data from the FIFO memory |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_rd_o | output | 1 | FIFO read strobe |
| rdata_o | output | DATA_W | Read data register |
| empty_ofs_o | output | BYTES_PER_OFS*SUB_W | Almost-empty threshold |
| full_ofs_o | output | BYTES_PER_OFS*SUB_W | Almost-full threshold |
| empty_vld_o | output | 1 | Almost-empty threshold valid |
| full_vld_o | output | 1 | Almost-full threshold valid |

## Verification
The assertions check the following on every cycle:
- the thresholds hold while load select is high, during a serial pause, and against byte writes in bit-load mode;
- the two valid outputs stay tied in bit-load mode;
- the write pointer steps and wraps;
- the readback pointer holds when idle;
- the mode does not move after reset;
- partial reset zeroes the read data.

Only the bench scenarios show the values of the data path. These cover byte order under interrupted sequences, the write-pointer wrap, the readback contents and wrap, the mapping of the serial bit string after pauses, and the per-flag valid timing in byte-load mode.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;
endpackage

// File: rtl/ofs_ptr.sv
module ofs_ptr #(
  parameter int N     = 4,
  localparam int PW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [PW-1:0] ptr_o
);
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ofs_serial_ctl.sv
module ofs_serial_ctl #(
  parameter int BITS  = 32,
  localparam int IW   = $clog2(BITS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  output logic [IW-1:0] idx_o,
  output logic          first_o,
  output logic          last_o
);
  localparam logic [IW-1:0] LAST = IW'(BITS - 1);

  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (shift_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o   = idx_q;
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == LAST);
endmodule

// File: rtl/ofs_store.sv
module ofs_store #(
  parameter int BPO             = 2,
  parameter int SUB_W           = 8,
  parameter int DFLT_PAR        = 127,
  parameter int DFLT_SER        = 1023,
  localparam int OFS_W          = BPO * SUB_W,
  localparam int NSUB           = 2 * BPO,
  localparam int PW             = $clog2(NSUB),
  localparam int IW             = $clog2(2 * OFS_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dflt_ser_i,
  input  logic             par_we_i,
  input  logic [PW-1:0]    par_idx_i,
  input  logic [SUB_W-1:0] par_byte_i,
  input  logic             ser_we_i,
  input  logic [IW-1:0]    ser_idx_i,
  input  logic             ser_bit_i,
  input  logic             ser_first_i,
  input  logic             ser_last_i,
  output logic [OFS_W-1:0] empty_ofs_o,
  output logic [OFS_W-1:0] full_ofs_o,
  output logic             empty_vld_o,
  output logic             full_vld_o
);
  localparam logic [OFS_W-1:0] D_PAR = OFS_W'(DFLT_PAR);
  localparam logic [OFS_W-1:0] D_SER = OFS_W'(DFLT_SER);

  logic [2*OFS_W-1:0] bank_q;
  logic               ev_q, fv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= dflt_ser_i ? {D_SER, D_SER} : {D_PAR, D_PAR};
    end else if (par_we_i) begin
      bank_q[par_idx_i*SUB_W +: SUB_W] <= par_byte_i;
    end else if (ser_we_i) begin
      bank_q[ser_idx_i] <= ser_bit_i;
    end
  end

  // validity: first byte/bit of a threshold drops it, last one raises it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q <= 1'b1;
      fv_q <= 1'b1;
    end else if (par_we_i) begin
      if (int'(par_idx_i) == 0)        ev_q <= 1'b0;
      if (int'(par_idx_i) == BPO - 1)  ev_q <= 1'b1;
      if (int'(par_idx_i) == BPO)      fv_q <= 1'b0;
      if (int'(par_idx_i) == NSUB - 1) fv_q <= 1'b1;
    end else if (ser_we_i) begin
      if (ser_first_i) begin
        ev_q <= 1'b0;
        fv_q <= 1'b0;
      end
      if (ser_last_i) begin
        ev_q <= 1'b1;
        fv_q <= 1'b1;
      end
    end
  end

  assign empty_ofs_o = bank_q[OFS_W-1:0];
  assign full_ofs_o  = bank_q[2*OFS_W-1:OFS_W];
  assign empty_vld_o = ev_q;
  assign full_vld_o  = fv_q;
endmodule

// File: rtl/flag_offset_bank.sv
module flag_offset_bank
  import ofs_pkg::*;
#(
  parameter int BYTES_PER_OFS = 2,
  parameter int SUB_W         = 8,
  parameter int DATA_W        = 9,
  parameter int DFLT_PAR      = 127,
  parameter int DFLT_SER      = 1023,
  localparam int OFS_W        = BYTES_PER_OFS * SUB_W,
  localparam int NSUB         = 2 * BYTES_PER_OFS,
  localparam int PW           = $clog2(NSUB),
  localparam int NBITS        = 2 * OFS_W,
  localparam int IW           = $clog2(NBITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prst_ni,
  input  logic              ld_ni,
  input  logic              sen_ni,
  input  logic              si_i,
  input  logic              wen_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_ni,
  input  logic [DATA_W-1:0] fifo_rdata_i,
  output logic              fifo_wr_o,
  output logic              fifo_rd_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [OFS_W-1:0]  empty_ofs_o,
  output logic [OFS_W-1:0]  full_ofs_o,
  output logic              empty_vld_o,
  output logic              full_vld_o
);
  initial begin
    if (BYTES_PER_OFS != 2 && BYTES_PER_OFS != 3)
      $error("BYTES_PER_OFS must be 2 or 3");
    if (SUB_W > DATA_W) $error("SUB_W exceeds DATA_W");
  end

  load_mode_e mode_q;
  logic       par_we, rb_adv, ser_shift;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [IW-1:0] ser_idx;
  logic       ser_first, ser_last;
  logic [SUB_W-1:0]  rb_byte;
  logic [DATA_W-1:0] rdata_q;

  // mode latched from load select while master reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= ld_ni ? LOAD_SER : LOAD_PAR;
  end

  assign par_we    = (mode_q == LOAD_PAR) && !ld_ni && !wen_ni;
  assign ser_shift = (mode_q == LOAD_SER) && !ld_ni && !sen_ni;
  assign rb_adv    = !ld_ni && !ren_ni;

  ofs_ptr #(.N(NSUB)) u_wr_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (par_we),
    .ptr_o (wr_ptr)
  );

  ofs_ptr #(.N(NSUB)) u_rd_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (rb_adv),
    .ptr_o (rd_ptr)
  );

  ofs_serial_ctl #(.BITS(NBITS)) u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(ser_shift),
    .idx_o  (ser_idx),
    .first_o(ser_first),
    .last_o (ser_last)
  );

  ofs_store #(
    .BPO     (BYTES_PER_OFS),
    .SUB_W   (SUB_W),
    .DFLT_PAR(DFLT_PAR),
    .DFLT_SER(DFLT_SER)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dflt_ser_i (ld_ni),
    .par_we_i   (par_we),
    .par_idx_i  (wr_ptr),
    .par_byte_i (wdata_i[SUB_W-1:0]),
    .ser_we_i   (ser_shift),
    .ser_idx_i  (ser_idx),
    .ser_bit_i  (si_i),
    .ser_first_i(ser_first),
    .ser_last_i (ser_last),
    .empty_ofs_o(empty_ofs_o),
    .full_ofs_o (full_ofs_o),
    .empty_vld_o(empty_vld_o),
    .full_vld_o (full_vld_o)
  );

  always_comb begin
    logic [2*OFS_W-1:0] flat;
    flat    = {full_ofs_o, empty_ofs_o};
    rb_byte = flat[rd_ptr*SUB_W +: SUB_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_q <= '0;
    else if (!prst_ni)           rdata_q <= '0;
    else if (rb_adv)             rdata_q <= DATA_W'(rb_byte);
    else if (ld_ni && !ren_ni)   rdata_q <= fifo_rdata_i;
  end

  assign rdata_o   = rdata_q;
  assign fifo_wr_o = ld_ni & ~wen_ni;
  assign fifo_rd_o = ld_ni & ~ren_ni;
endmodule

// File: rtl/ofs_bank_chk.sv
module ofs_bank_chk #(
  parameter int NSUB   = 4,
  parameter int OFS_W  = 16,
  parameter int DATA_W = 9,
  localparam int PW    = $clog2(NSUB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prst_ni,
  input logic              ld_ni,
  input logic              sen_ni,
  input logic              wen_ni,
  input logic              ren_ni,
  input logic              mode_ser,
  input logic [PW-1:0]     wr_ptr,
  input logic [PW-1:0]     rd_ptr,
  input logic [DATA_W-1:0] rdata_o,
  input logic [OFS_W-1:0]  empty_ofs_o,
  input logic [OFS_W-1:0]  full_ofs_o,
  input logic              empty_vld_o,
  input logic              full_vld_o
);
  p_ld_high_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> $stable(empty_ofs_o) && $stable(full_ofs_o));

  p_ser_pause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser && sen_ni) |=> $stable(empty_ofs_o) && $stable(full_ofs_o));

  p_par_lock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser && !ld_ni && !wen_ni && sen_ni) |=> $stable({full_ofs_o, empty_ofs_o}));

  p_ser_vld_tied_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ser |-> (empty_vld_o == full_vld_o));

  p_prst_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prst_ni |=> (rdata_o == '0));

  p_wr_ptr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_ser && !ld_ni && !wen_ni) |=>
      (wr_ptr == ((int'($past(wr_ptr)) == NSUB - 1) ? '0 : $past(wr_ptr) + 1'b1)));

  p_rd_ptr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_ni || ren_ni) |=> $stable(rd_ptr));

  p_mode_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(mode_ser));
endmodule

bind flag_offset_bank ofs_bank_chk #(
  .NSUB  (NSUB),
  .OFS_W (OFS_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .prst_ni    (prst_ni),
  .ld_ni      (ld_ni),
  .sen_ni     (sen_ni),
  .wen_ni     (wen_ni),
  .ren_ni     (ren_ni),
  .mode_ser   (mode_q == ofs_pkg::LOAD_SER),
  .wr_ptr     (wr_ptr),
  .rd_ptr     (rd_ptr),
  .rdata_o    (rdata_o),
  .empty_ofs_o(empty_ofs_o),
  .full_ofs_o (full_ofs_o),
  .empty_vld_o(empty_vld_o),
  .full_vld_o (full_vld_o)
);

// File: tb/flag_offset_bank_tb.sv
`timescale 1ns/1ps
module flag_offset_bank_tb;
  localparam int BPO    = 2;
  localparam int SUB_W  = 8;
  localparam int DATA_W = 9;
  localparam int OFS_W  = BPO * SUB_W;
  localparam int NSUB   = 2 * BPO;
  localparam int NBITS  = 2 * OFS_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1, ld_n = 1'b0, sen_n = 1'b1, si = 1'b0;
  logic wen_n = 1'b1, ren_n = 1'b1;
  logic [DATA_W-1:0] wdata = '0, fdata = '0;
  logic fifo_wr, fifo_rd, ev, fv;
  logic [DATA_W-1:0] rdata;
  logic [OFS_W-1:0] eofs, fofs;

  always #2.5 clk = ~clk;

  flag_offset_bank #(.BYTES_PER_OFS(BPO), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prst_ni(prst_n), .ld_ni(ld_n), .sen_ni(sen_n),
    .si_i(si), .wen_ni(wen_n), .wdata_i(wdata), .ren_ni(ren_n),
    .fifo_rdata_i(fdata), .fifo_wr_o(fifo_wr), .fifo_rd_o(fifo_rd),
    .rdata_o(rdata), .empty_ofs_o(eofs), .full_ofs_o(fofs),
    .empty_vld_o(ev), .full_vld_o(fv));

  int n_chk = 0, n_err = 0;
  string cur_req = "R8";

  // reference model
  logic [SUB_W-1:0] m_b [NSUB];
  bit m_ser, m_ev, m_fv;
  int m_wp, m_rp, m_bit;
  logic [DATA_W-1:0] m_rd;

  function automatic logic [OFS_W-1:0] m_ofs(int which);
    logic [OFS_W-1:0] v = '0;
    for (int k = 0; k < BPO; k++) v[k*SUB_W +: SUB_W] = m_b[which*BPO + k];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ser = ld_n;
      for (int k = 0; k < NSUB; k++)
        m_b[k] = ld_n ? ((k % BPO == 0) ? 8'hFF : (k % BPO == 1) ? 8'h03 : 8'h00)
                      : ((k % BPO == 0) ? 8'h7F : 8'h00);
      m_ev = 1; m_fv = 1; m_wp = 0; m_rp = 0; m_bit = 0; m_rd = '0;
    end else begin
      if (!prst_n) m_rd = '0;
      else if (!ld_n && !ren_n) m_rd = DATA_W'(m_b[m_rp]);
      else if (ld_n && !ren_n) m_rd = fdata;
      if (!ld_n && !ren_n) m_rp = (m_rp + 1) % NSUB;
      if (!ld_n && !m_ser && !wen_n) begin
        m_b[m_wp] = wdata[SUB_W-1:0];
        if (m_wp == 0) m_ev = 0;
        if (m_wp == BPO - 1) m_ev = 1;
        if (m_wp == BPO) m_fv = 0;
        if (m_wp == NSUB - 1) m_fv = 1;
        m_wp = (m_wp + 1) % NSUB;
      end
      if (!ld_n && m_ser && !sen_n) begin
        m_b[m_bit / SUB_W][m_bit % SUB_W] = si;
        if (m_bit == 0) begin m_ev = 0; m_fv = 0; end
        if (m_bit == NBITS - 1) begin m_ev = 1; m_fv = 1; end
        m_bit = (m_bit + 1) % NBITS;
      end
    end
  end

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the clock edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      chk(cur_req, "empty_ofs", eofs, m_ofs(0));
      chk(cur_req, "full_ofs", fofs, m_ofs(1));
      chk(cur_req, "empty_vld", ev, m_ev);
      chk(cur_req, "full_vld", fv, m_fv);
      chk(cur_req, "rdata", rdata, m_rd);
      chk("R11", "fifo_wr", fifo_wr, ld_n & ~wen_n);
      chk("R11", "fifo_rd", fifo_rd, ld_n & ~ren_n);
    end
  end

  task automatic cyc(logic l, logic w, logic s, logic r, logic b,
                     logic [DATA_W-1:0] d, logic [DATA_W-1:0] f);
    @(negedge clk);
    ld_n = l; wen_n = w; sen_n = s; ren_n = r; si = b; wdata = d; fdata = f;
  endtask

  task automatic idle(); cyc(1, 1, 1, 1, 0, '0, '0); endtask

  task automatic do_reset(logic l);
    @(negedge clk);
    ld_n = l; wen_n = 1; sen_n = 1; ren_n = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  logic [31:0] pat = 32'hA5C3_1E7B;

  initial begin
    // R8: byte-load mode after reset with load select low
    do_reset(1'b0);
    idle(); @(negedge clk); #1;
    chk("R8", "reset empty", eofs, 16'd127);
    chk("R8", "reset full", fofs, 16'd127);
    chk("R8", "reset rdata", rdata, 0);

    // R2/R7: byte writes interrupted by FIFO writes
    cur_req = "R2";
    cyc(0, 0, 1, 1, 0, 9'h111, 0);
    cyc(1, 0, 1, 1, 0, 9'h0EE, 0);           // R11 FIFO write, offsets hold
    @(negedge clk); #1;
    chk("R7", "empty vld after LSB", ev, 0);
    chk("R7", "full vld untouched", fv, 1);
    cur_req = "R7";
    cyc(0, 0, 1, 1, 0, 9'h122, 0);
    cyc(0, 0, 1, 1, 0, 9'h033, 0);
    idle();
    cyc(0, 0, 1, 1, 0, 9'h044, 0);
    idle(); @(negedge clk); #1;
    chk("R1", "empty after bytes", eofs, 16'h2211);
    chk("R1", "full after bytes", fofs, 16'h4433);
    cur_req = "R2";
    cyc(0, 0, 1, 1, 0, 9'h055, 0);           // wraps to empty LSB
    idle(); @(negedge clk); #1;
    chk("R2", "wrap to empty LSB", eofs, 16'h2255);
    // R9: serial pins ignored in byte mode
    cur_req = "R9";
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 1, i[0], 0, 0);
    idle(); @(negedge clk); #1;
    chk("R9", "serial ignored", {fofs, eofs}, 32'h4433_2255);

    // R3: readback with interruption and wrap
    cur_req = "R3";
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(1, 1, 1, 0, 0, 0, 9'h1AB);           // R11 FIFO read
    idle(); #1;
    chk("R11", "fifo data captured", rdata, 9'h1AB);
    cur_req = "R3";
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 0, 0);
    idle(); #1;
    chk("R3", "readback wrap", rdata, 9'h055);

    // R10: partial reset
    cur_req = "R10";
    @(negedge clk); prst_n = 0;
    @(negedge clk); prst_n = 1; #1;
    chk("R10", "prst clears rdata", rdata, 0);
    chk("R10", "prst keeps offsets", {fofs, eofs}, 32'h4433_2255);
    cyc(0, 1, 1, 0, 0, 0, 0);
    idle(); #1;
    chk("R10", "readback ptr kept", rdata, 9'h022);

    // R8: bit-load mode
    cur_req = "R8";
    do_reset(1'b1);
    idle(); @(negedge clk); #1;
    chk("R8", "serial default empty", eofs, 16'd1023);
    chk("R8", "serial default full", fofs, 16'd1023);
    // R4/R5/R6: shift with pauses
    cur_req = "R4";
    for (int i = 0; i < NBITS; i++) begin
      cyc(0, 1, 0, 1, pat[i], 0, 0);
      if (i == 5) begin
        cur_req = "R5";
        cyc(0, 1, 1, 1, ~pat[i+1], 0, 0);
        cyc(1, 1, 0, 1, ~pat[i+1], 0, 0);
        cyc(0, 0, 1, 1, 0, 9'h1FF, 0);       // R9 byte write blocked
        @(negedge clk); #1;
        chk("R6", "vld low mid-load", {ev, fv}, 2'b00);
        cur_req = "R4";
      end
    end
    idle(); @(negedge clk); #1;
    chk("R4", "serial empty", eofs, pat[15:0]);
    chk("R4", "serial full", fofs, pat[31:16]);
    chk("R6", "vld after last bit", {ev, fv}, 2'b11);
    // R3: readback allowed in bit-load mode
    cur_req = "R3";
    cyc(0, 1, 1, 0, 0, 0, 0);
    idle(); #1;
    chk("R3", "serial-mode readback", rdata, {1'b0, pat[7:0]});
    repeat (3) idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule